// File: doc/BRIEF.md
# Vectored Interrupt Trap Entry Unit

This block sequences machine-mode trap entry and trap return for a core-local interrupt controller that works with interrupt levels. An already-arbitrated request arrives with a 10-bit identifier, an 8-bit level and a flag that selects vectored or non-vectored dispatch. On entry the block packs the cause register, saves the interrupted program counter and enable state, raises the current interrupt level, and produces the next program counter. A vectored request reads the handler address from a table in memory, using one 32-bit read. A non-vectored request jumps to a base register.

On return the block restores the saved interrupt level, the enable state and the privilege, and sends the core back to the saved program counter. A synchronous exception is handled as a plain trap to the trap-vector base. The block holds its own registers behind a small CSR port. Index 0 is the trap-vector base, 1 the vector-table base, 2 the alternate base, 3 cause, 4 interrupt status, 5 saved PC, 6 machine status, and 7 the current privilege, which is read-only.

Top module: `vec_trap_seq`

## Requirements
- R1: After reset, CSR indices 0 to 6 read zero, index 7 reads 3 (machine privilege), and pc_load, mem_req_valid and busy are low.
- R2: A write to the trap-vector base (index 0) is kept when bit 1 of the data is 0, or when data[5:0] equals 6'b000011. Any other write is dropped. Controller mode is on exactly when the stored bits [5:0] equal 6'b000011. Interrupt requests are not taken outside controller mode.
- R3: irq_take is high in the same cycle as irq_req only when all of these hold: the unit is idle, no exception is requested, controller mode is on, and either the privilege is below 3 or the global enable (status bit 3) is 1.
- R4: When an interrupt is taken, cause becomes {1, vectored flag at bit 30, interrupted privilege [29:28], old global enable bit 27, zeros [26:24], old machine level [23:16], zeros [15:10], id [9:0]}. Status bits [31:24] take the new level, and status bits [7:0] are kept.
- R5: Any trap entry saves pc_in to the saved PC register. It moves the global enable into the previous-enable bit (status bit 7) and then clears the global enable. It saves the privilege in status [12:11] and sets the privilege to 3.
- R6: On a non-vectored interrupt, pc_load pulses in the cycle after acceptance. If bit 0 of the alternate base is 1, pc_next is the alternate base with bits [1:0] cleared. Otherwise pc_next is the trap-vector base with bits [1:0] cleared.
- R7: On a vectored interrupt, mem_req_valid rises in the cycle after acceptance, with address vector_table_base + id*4. The request holds with a stable address until mem_req_ready is high. After that the unit waits for mem_rsp_valid. It then pulses pc_load with mem_rsp_data and clears cause bit 30, which was set while the handler address was being fetched.
- R8: An exception takes priority over an interrupt in the same cycle and is accepted in any mode. Cause becomes {0, zeros, code[11:0]} and pc_next is the trap-vector base with bits [1:0] cleared.
- R9: A return sends the core to the saved PC, copies the previous enable back to the global enable, and sets the previous enable to 1. In controller mode it also restores status [31:24] from cause [23:16]. If controller mode is on and cause bit 31 is 1, the privilege and status [12:11] both take cause [29:28]. Otherwise the privilege takes status [12:11] and that field is cleared.
- R10: The interrupt status register stores only bits [31:24] and [7:0]. The machine status register stores only bits 3, 7 and [12:11]. All other bits read zero.
- R11: While a vectored fetch is outstanding (busy high), interrupt, exception and return requests are ignored. In an idle cycle the priority order is exception, then interrupt, then return. A CSR write is dropped in a cycle that accepts one of these events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 3 | CSR index for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| irq_req | input | 1 | Arbitrated interrupt request |
| irq_id | input | 10 | Interrupt identifier |
| irq_lvl | input | 8 | Interrupt level |
| irq_shv | input | 1 | 1 selects vectored dispatch |
| irq_take | output | 1 | Interrupt accepted this cycle |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 12 | Exception code |
| ret_req | input | 1 | Trap return request |
| pc_in | input | 32 | Program counter of the interrupted instruction |
| pc_load | output | 1 | One-cycle pulse: load pc_next |
| pc_next | output | 32 | New program counter |
| mem_req_valid | output | 1 | Vector-table read request |
| mem_req_ready | input | 1 | Request accepted by memory |
| mem_req_addr | output | 32 | Vector-table word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Handler address read from the table |
| busy | output | 1 | Vectored fetch in progress |

## Verification
The checks on the fetch handshake assume that memory returns mem_rsp_valid only after it has accepted a request, and never in the same cycle as the acceptance. The bench memory model waits one clock after ready before it drives a response. The properties also assume that the level, vectored flag and id are stable for the cycle in which the request is accepted. Every directed task drives them from one falling edge and releases them at the next one. Conflicting requests are applied on purpose only in the exception-priority and busy scenarios.

// File: rtl/vec_trap_seq.sv
`timescale 1ns/10ps
module vec_trap_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [2:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        irq_req,
  input  logic [9:0]  irq_id,
  input  logic [7:0]  irq_lvl,
  input  logic        irq_shv,
  output logic        irq_take,
  input  logic        exc_req,
  input  logic [11:0] exc_code,
  input  logic        ret_req,
  input  logic [31:0] pc_in,
  output logic        pc_load,
  output logic [31:0] pc_next,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        busy
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t         st_q;
  logic [31:0] tvec_q, vtb_q, alt_q, cause_q, ist_q, epc_q, maddr_q;
  logic        mie_q, mpie_q;
  logic [1:0]  mpp_q, priv_q;

  wire idle      = (st_q == S_IDLE);
  wire clic_mode = (tvec_q[5:0] == 6'b000011);
  wire irq_en    = (priv_q != 2'b11) || mie_q;
  wire exc_take  = idle && exc_req;
  assign irq_take = idle && !exc_req && irq_req && clic_mode && irq_en;
  wire ret_take  = idle && !exc_req && !irq_take && ret_req;
  wire evt       = exc_take || irq_take || ret_take;
  wire csr_go    = csr_we && !evt;
  wire tvec_ok   = !csr_wdata[1] || (csr_wdata[5:0] == 6'b000011);

  wire [31:0] base_tgt = tvec_q & ~32'h3;
  wire [31:0] nv_tgt   = alt_q[0] ? (alt_q & ~32'h3) : base_tgt;
  wire        ret_from_cause = clic_mode && cause_q[31];
  wire [1:0]  ret_priv = ret_from_cause ? cause_q[29:28] : mpp_q;
  wire [31:0] mstat    = {19'b0, mpp_q, 3'b0, mpie_q, 3'b0, mie_q, 3'b0};

  assign busy          = !idle;
  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = maddr_q;

  always_comb begin
    case (csr_addr)
      3'd0:    csr_rdata = tvec_q;
      3'd1:    csr_rdata = vtb_q;
      3'd2:    csr_rdata = alt_q;
      3'd3:    csr_rdata = cause_q;
      3'd4:    csr_rdata = ist_q;
      3'd5:    csr_rdata = epc_q;
      3'd6:    csr_rdata = mstat;
      default: csr_rdata = {30'b0, priv_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      tvec_q  <= '0;
      vtb_q   <= '0;
      alt_q   <= '0;
      cause_q <= '0;
      ist_q   <= '0;
      epc_q   <= '0;
      maddr_q <= '0;
      mie_q   <= 1'b0;
      mpie_q  <= 1'b0;
      mpp_q   <= 2'b00;
      priv_q  <= 2'b11;
      pc_load <= 1'b0;
      pc_next <= '0;
    end else begin
      pc_load <= 1'b0;

      if (csr_go) begin
        case (csr_addr)
          3'd0: if (tvec_ok) tvec_q <= csr_wdata;
          3'd1: vtb_q   <= csr_wdata;
          3'd2: alt_q   <= csr_wdata;
          3'd3: cause_q <= csr_wdata;
          3'd4: ist_q   <= {csr_wdata[31:24], 16'b0, csr_wdata[7:0]};
          3'd5: epc_q   <= csr_wdata;
          3'd6: begin
            mie_q  <= csr_wdata[3];
            mpie_q <= csr_wdata[7];
            mpp_q  <= csr_wdata[12:11];
          end
          default: ;
        endcase
      end

      if (exc_take || irq_take) begin
        epc_q  <= pc_in;
        mie_q  <= 1'b0;
        mpie_q <= mie_q;
        mpp_q  <= priv_q;
        priv_q <= 2'b11;
      end

      if (exc_take) begin
        cause_q <= {20'b0, exc_code};
        pc_load <= 1'b1;
        pc_next <= base_tgt;
      end else if (irq_take) begin
        cause_q <= {1'b1, irq_shv, priv_q, mie_q, 3'b0, ist_q[31:24], 6'b0, irq_id};
        ist_q[31:24] <= irq_lvl;
        if (irq_shv) begin
          st_q    <= S_REQ;
          maddr_q <= vtb_q + {20'b0, irq_id, 2'b00};
        end else begin
          pc_load <= 1'b1;
          pc_next <= nv_tgt;
        end
      end else if (ret_take) begin
        pc_load <= 1'b1;
        pc_next <= epc_q;
        mie_q   <= mpie_q;
        mpie_q  <= 1'b1;
        priv_q  <= ret_priv;
        mpp_q   <= ret_from_cause ? cause_q[29:28] : 2'b00;
        if (clic_mode) ist_q[31:24] <= cause_q[23:16];
      end

      case (st_q)
        S_REQ:  if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          st_q        <= S_IDLE;
          pc_load     <= 1'b1;
          pc_next     <= mem_rsp_data;
          cause_q[30] <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vec_trap_seq_chk.sv
`timescale 1ns/10ps
module vec_trap_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_take,
  input logic [7:0]  irq_lvl,
  input logic        exc_req,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        pc_load,
  input logic        busy,
  input logic [31:0] tvec_q,
  input logic [31:0] cause_q,
  input logic [31:0] ist_q,
  input logic [1:0]  priv_q,
  input logic        mie_q
);
  a_r2_mode_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    tvec_q[1] |-> tvec_q[5:0] == 6'b000011);

  a_r3_take_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((priv_q != 2'b11) || mie_q) && !busy);

  a_r4_level_update: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (ist_q[31:24] == $past(irq_lvl)) && cause_q[31]);

  a_r5_enter_machine: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (priv_q == 2'b11) && !mie_q);

  a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r7_rsp_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_req_valid && mem_rsp_valid |=> pc_load && !busy);

  a_r8_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && !busy |-> !irq_take);
endmodule

bind vec_trap_seq vec_trap_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_lvl(irq_lvl),
  .exc_req(exc_req), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .pc_load(pc_load),
  .busy(busy), .tvec_q(tvec_q), .cause_q(cause_q), .ist_q(ist_q),
  .priv_q(priv_q), .mie_q(mie_q)
);

// File: tb/vec_trap_seq_tb.sv
`timescale 1ns/10ps
module vec_trap_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq_req = 1'b0;
  logic [9:0]  irq_id = '0;
  logic [7:0]  irq_lvl = '0;
  logic        irq_shv = 1'b0;
  logic        irq_take;
  logic        exc_req = 1'b0;
  logic [11:0] exc_code = '0;
  logic        ret_req = 1'b0;
  logic [31:0] pc_in = '0;
  logic        pc_load;
  logic [31:0] pc_next;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vec_trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_req(irq_req),
    .irq_id(irq_id), .irq_lvl(irq_lvl), .irq_shv(irq_shv), .irq_take(irq_take),
    .exc_req(exc_req), .exc_code(exc_code), .ret_req(ret_req), .pc_in(pc_in),
    .pc_load(pc_load), .pc_next(pc_next), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_csr(input string tag, input logic [2:0] a, input logic [31:0] exp);
    csr_addr = a;
    #0.2;
    chk(tag, csr_rdata, exp);
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic fire_irq(input logic [9:0] id, input logic [7:0] lvl, input logic shv,
                          input logic [31:0] pc, input logic exp_take, input string tag);
    irq_req = 1'b1; irq_id = id; irq_lvl = lvl; irq_shv = shv; pc_in = pc;
    #0.2;
    chk(tag, {31'b0, irq_take}, {31'b0, exp_take});
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  task automatic fire_ret();
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) chk_csr("R1 csr reset", 3'(i), 32'h0);
    chk_csr("R1 priv reset", 3'd7, 32'h3);
    chk("R1 pc_load reset", {31'b0, pc_load}, 32'h0);
    chk("R1 req reset", {30'b0, mem_req_valid, busy}, 32'h0);
  endtask

  task automatic t_tvec();
    csr_wr(3'd0, 32'h1000_0001);
    chk_csr("R2 tvec mode1 kept", 3'd0, 32'h1000_0001);
    csr_wr(3'd0, 32'h2000_0002);
    chk_csr("R2 tvec mode2 dropped", 3'd0, 32'h1000_0001);
    csr_wr(3'd0, 32'h8000_0003);
    chk_csr("R2 tvec ctrl kept", 3'd0, 32'h8000_0003);
    csr_wr(3'd0, 32'h8000_0013);
    chk_csr("R2 tvec bad pattern dropped", 3'd0, 32'h8000_0003);
  endtask

  task automatic t_masked();
    fire_irq(10'd1, 8'h09, 1'b0, 32'h100, 1'b0, "R3 masked in M with enable 0");
    chk("R3 no load when masked", {31'b0, pc_load}, 32'h0);
    chk_csr("R3 cause untouched", 3'd3, 32'h0);
  endtask

  task automatic t_fields();
    csr_wr(3'd4, 32'hFFFF_FFFF);
    chk_csr("R10 status mask", 3'd4, 32'hFF00_00FF);
    csr_wr(3'd4, 32'h0500_0034);
    chk_csr("R10 status value", 3'd4, 32'h0500_0034);
    csr_wr(3'd6, 32'hFFFF_FFFF);
    chk_csr("R10 mstatus mask", 3'd6, 32'h0000_1888);
    csr_wr(3'd6, 32'h0000_1008);
    chk_csr("R10 mstatus value", 3'd6, 32'h0000_1008);
  endtask

  task automatic t_nonvec();
    fire_irq(10'h155, 8'h40, 1'b0, 32'h0000_2000, 1'b1, "R3 take in M with enable 1");
    chk("R6 pc_load", {31'b0, pc_load}, 32'h1);
    chk("R6 target tvec", pc_next, 32'h8000_0000);
    chk_csr("R4 cause packed", 3'd3, 32'hB805_0155);
    chk_csr("R4 level raised", 3'd4, 32'h4000_0034);
    chk_csr("R5 epc saved", 3'd5, 32'h0000_2000);
    chk_csr("R5 mstatus on entry", 3'd6, 32'h0000_1880);
    chk_csr("R5 priv machine", 3'd7, 32'h3);
    @(negedge clk);
    chk("R6 pc_load one cycle", {31'b0, pc_load}, 32'h0);
  endtask

  task automatic t_return();
    fire_ret();
    chk("R9 return load", {31'b0, pc_load}, 32'h1);
    chk("R9 return target", pc_next, 32'h0000_2000);
    chk_csr("R9 level restored", 3'd4, 32'h0500_0034);
    chk_csr("R9 mstatus restored", 3'd6, 32'h0000_1888);
    chk_csr("R9 priv from cause", 3'd7, 32'h3);
  endtask

  task automatic t_alt();
    csr_wr(3'd2, 32'h0000_4007);
    csr_wr(3'd3, 32'h0);
    csr_wr(3'd6, 32'h0000_0080);
    fire_ret();
    chk_csr("R9 priv from status field", 3'd7, 32'h0);
    chk_csr("R9 mstatus after plain return", 3'd6, 32'h0000_0088);
    chk_csr("R9 level from zero cause", 3'd4, 32'h0000_0034);
    csr_wr(3'd6, 32'h0000_0080);
    fire_irq(10'd3, 8'h22, 1'b0, 32'h0000_3000, 1'b1, "R3 take below machine with enable 0");
    chk("R6 alt target", pc_next, 32'h0000_4004);
    chk("R6 alt load", {31'b0, pc_load}, 32'h1);
    chk_csr("R4 cause from user", 3'd3, 32'h8000_0003);
    chk_csr("R4 level 22", 3'd4, 32'h2200_0034);
    chk_csr("R5 mstatus user entry", 3'd6, 32'h0000_0000);
    chk_csr("R5 priv raised", 3'd7, 32'h3);
  endtask

  task automatic t_vec();
    csr_wr(3'd1, 32'h0001_0000);
    csr_wr(3'd6, 32'h0000_0008);
    fire_irq(10'h3FF, 8'h77, 1'b1, 32'h0000_5000, 1'b1, "R7 vectored take");
    chk("R7 req valid", {31'b0, mem_req_valid}, 32'h1);
    chk("R7 req addr", mem_req_addr, 32'h0001_0FFC);
    chk("R7 no early load", {31'b0, pc_load}, 32'h0);
    chk_csr("R7 cause fetching", 3'd3, 32'hF822_03FF);
    ret_req = 1'b1; irq_req = 1'b1; irq_id = 10'd2; irq_shv = 1'b0;
    #0.2;
    chk("R11 irq ignored busy", {31'b0, irq_take}, 32'h0);
    @(negedge clk);
    ret_req = 1'b0; irq_req = 1'b0;
    chk("R11 return ignored busy", {31'b0, pc_load}, 32'h0);
    chk("R7 req held", {31'b0, mem_req_valid}, 32'h1);
    chk("R7 addr held", mem_req_addr, 32'h0001_0FFC);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R7 single request", {31'b0, mem_req_valid}, 32'h0);
    chk("R7 waiting", {30'b0, busy, pc_load}, 32'h2);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEE0;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R7 load on response", {31'b0, pc_load}, 32'h1);
    chk("R7 handler addr", pc_next, 32'hDEAD_BEE0);
    chk_csr("R7 fetch flag cleared", 3'd3, 32'hB822_03FF);
    chk("R7 idle", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_exc();
    csr_wr(3'd6, 32'h0000_0008);
    exc_req = 1'b1; exc_code = 12'h00B; pc_in = 32'h0000_7000;
    irq_req = 1'b1; irq_id = 10'd7; irq_lvl = 8'h50; irq_shv = 1'b0;
    #0.2;
    chk("R8 irq loses to exception", {31'b0, irq_take}, 32'h0);
    @(negedge clk);
    exc_req = 1'b0; irq_req = 1'b0;
    chk("R8 exc load", {31'b0, pc_load}, 32'h1);
    chk("R8 exc target", pc_next, 32'h8000_0000);
    chk_csr("R8 exc cause", 3'd3, 32'h0000_000B);
    chk_csr("R8 exc epc", 3'd5, 32'h0000_7000);
    chk_csr("R8 level kept", 3'd4, 32'h7700_0034);
  endtask

  task automatic t_plainmode();
    csr_wr(3'd0, 32'h0000_1000);
    csr_wr(3'd6, 32'h0000_0008);
    fire_irq(10'd5, 8'h10, 1'b0, 32'h0000_6000, 1'b0, "R2 irq ignored outside ctrl mode");
    chk("R2 no load outside ctrl mode", {31'b0, pc_load}, 32'h0);
    exc_req = 1'b1; exc_code = 12'h002; pc_in = 32'h0000_6000;
    @(negedge clk);
    exc_req = 1'b0;
    chk("R8 exc in plain mode", pc_next, 32'h0000_1000);
    chk_csr("R8 exc cause plain", 3'd3, 32'h0000_0002);
  endtask

  initial begin
    t_reset();
    t_tvec();
    t_masked();
    t_fields();
    t_nonvec();
    t_return();
    t_alt();
    t_vec();
    t_exc();
    t_plainmode();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule